// File: doc/BRIEF.md
# Instruction Line Fetch Slave with Fault Capture

This block answers instruction line reads from a fetch unit over a read-only bus. A request is granted in the cycle it is raised while the slave is idle. The words of the line then come back one per cycle from a small internal array, with no gap between them. By default the first word arrives in the cycle right after the grant. A control bit adds one wait cycle, so the first word arrives two cycles after the grant, which models a slower bus.

For fault testing, a control field picks one word of each line to carry a bus error. A line address past the end of the array also produces an error. A fault never cuts the line short: every word is still returned. The fault marker is raised only on the faulting word's acknowledge. The byte address of the first fault, its cause and its word index are latched in two registers. A small configuration port can read those registers and clear them.

Top module: `isb_slave`

## Requirements
- R1: When idle, a request (`req_i`=1) is granted through `req_ack_o` in the same cycle. `busy_o` is high from the next cycle through the last word of the line. While `busy_o` is high, no request is granted.
- R2: With control bit 1 clear, the first `rd_ack_o` comes in the cycle after the grant. With control bit 1 set, one idle cycle follows the grant and the first `rd_ack_o` comes two cycles after it.
- R3: A line is 8 words returned on 8 consecutive `rd_ack_o` cycles, with no gaps, in word order 0 to 7. `busy_o` drops in the cycle after the last word.
- R4: The word at word index w (line * 8 + word) is `{w[15:0] ^ 16'hC0DE, ~w[15:0]}`. A line index of 16 or more returns all-zero data. `rd_data_o` is zero whenever `rd_ack_o` is low.
- R5: If control bit 0 is set, `rd_err_o` is raised for one cycle together with the `rd_ack_o` of the word selected by control bits [4:2], and all 8 words are still delivered. The control value is sampled at the grant; later writes do not affect a line in progress.
- R6: For a line index of 16 or more, `rd_err_o` is raised only on word 0, with cause code 3. Injection is not applied to that line.
- R7: On a fault, config address 1 returns the byte address of the faulting word: `{line, word, 2'b00}`. Config address 2 returns the syndrome: bit 0 valid, bits [2:1] cause (1 = injected, 3 = address out of range), bits [5:3] word index. Reads are combinational.
- R8: While the valid bit is set, later faults change neither the address register nor the syndrome register.
- R9: Writing a 1 to bit 0 at config address 2 clears both fault registers to zero. Writing a 0 there, or writing to address 1, has no effect. A fault arriving in the same cycle as a clear is captured.
- R10: Config address 0 reads back the control bits in their write positions. Address 3 reads zero. After reset, every register and every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Line fetch request |
| req_line_i | input | 11 | Line index (byte address bits above the line offset) |
| req_ack_o | output | 1 | Request grant, same cycle |
| busy_o | output | 1 | Line transfer in progress |
| rd_ack_o | output | 1 | Read-data acknowledge for one word |
| rd_data_o | output | 32 | Instruction word |
| rd_err_o | output | 1 | Bus error on the current word |
| cfg_addr_i | input | 2 | Config register select |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_wdata_i | input | 5 | Config write data |
| cfg_rdata_o | output | 16 | Config read data |

## Verification
The bench targets the cycle right after the grant and the extra wait cycle in the slow mode. A design that miscounted these would be off by one word against the model on every cycle after. Faults are placed on word 0 and on word 7. A slave that ended the line early or held the error for two cycles would show a missing acknowledge or a stray `rd_err_o`. The bench also clears the fault registers in the very cycle of a new fault, changes the control value in the middle of a line, and requests a line past the array. A design that let the clear win, that did not sample the control at the grant, or that injected on an out-of-range line would latch the wrong syndrome or address.

// File: rtl/isb_pkg.sv
// Shared definitions for the instruction line fetch slave.
// Assumes a 32-bit instruction word and a 2-bit config register select.
package isb_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HOLD = 2'd1,
        SEQ_BEAT = 2'd2
    } seq_state_e;

    localparam logic [1:0] CAUSE_INJECT = 2'b01;
    localparam logic [1:0] CAUSE_RANGE  = 2'b11;

    localparam logic [1:0] CFG_CTRL  = 2'd0;
    localparam logic [1:0] CFG_EADDR = 2'd1;
    localparam logic [1:0] CFG_SYND  = 2'd2;

    // Content of the backing array, as a function of the word index.
    function automatic logic [WORD_W-1:0] fill_word(input int unsigned idx);
        logic [15:0] w;
        w = idx[15:0];
        return {w ^ 16'hC0DE, ~w};
    endfunction

endpackage

// File: rtl/isb_line_rom.sv
// Backing array of instruction words. The contents are computed from the
// word index. The read is combinational.
// Assumes the caller masks the data for indices outside the array.
module isb_line_rom
    import isb_pkg::*;
#(
    parameter int DEPTH_WORDS = 128,
    localparam int IW = $clog2(DEPTH_WORDS)
) (
    input  logic [IW-1:0]     rd_idx_i,
    output logic [WORD_W-1:0] rd_word_o
);

    logic [WORD_W-1:0] table_w [DEPTH_WORDS];

    // Fill every entry from the content function.
    for (genvar i = 0; i < DEPTH_WORDS; i++) begin : g_fill
        assign table_w[i] = fill_word(i);
    end

    // Select the addressed word.
    assign rd_word_o = table_w[rd_idx_i];

endmodule

// File: rtl/isb_beat_seq.sv
// Line transfer sequencer. It grants a request in the cycle it appears when
// idle. It can insert one wait cycle. It then walks through the words of the
// line on consecutive cycles and decides which word carries a fault.
// Assumes the fault settings are sampled at the grant.
module isb_beat_seq
    import isb_pkg::*;
#(
    parameter int LAW   = 11,
    parameter int BW    = 3,
    parameter int LINES = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_i,
    input  logic [LAW-1:0] req_line_i,
    input  logic           slow_i,
    input  logic           inj_en_i,
    input  logic [BW-1:0]  inj_beat_i,
    output logic           req_ack_o,
    output logic           busy_o,
    output logic           beat_ack_o,
    output logic [BW-1:0]  beat_idx_o,
    output logic [LAW-1:0] line_o,
    output logic           line_bad_o,
    output logic           beat_err_o,
    output logic [1:0]     err_cause_o
);

    localparam logic [BW-1:0] LAST_BEAT  = '1;
    localparam logic [LAW:0]  LINE_LIMIT = (LAW+1)'(LINES);

    seq_state_e     state_q;
    logic [BW-1:0]  beat_q;
    logic [BW-1:0]  inj_beat_q;
    logic [LAW-1:0] line_q;
    logic           bad_q;
    logic           inj_en_q;
    logic           hit_range;
    logic           hit_inject;

    // Grant only while no line is being served.
    assign req_ack_o = req_i && (state_q == SEQ_IDLE);

    // Step through grant, optional wait, and the word stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SEQ_IDLE;
            beat_q     <= '0;
            inj_beat_q <= '0;
            line_q     <= '0;
            bad_q      <= 1'b0;
            inj_en_q   <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (req_i) begin
                        line_q     <= req_line_i;
                        bad_q      <= {1'b0, req_line_i} >= LINE_LIMIT;
                        inj_en_q   <= inj_en_i;
                        inj_beat_q <= inj_beat_i;
                        beat_q     <= '0;
                        state_q    <= slow_i ? SEQ_HOLD : SEQ_BEAT;
                    end
                end
                SEQ_HOLD: state_q <= SEQ_BEAT;
                SEQ_BEAT: begin
                    if (beat_q == LAST_BEAT) begin
                        state_q <= SEQ_IDLE;
                    end else begin
                        beat_q <= beat_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Decide whether the current word is faulted, and why.
    always_comb begin
        hit_range   = bad_q && (beat_q == '0);
        hit_inject  = inj_en_q && (beat_q == inj_beat_q);
        beat_err_o  = beat_ack_o && (bad_q ? hit_range : hit_inject);
        err_cause_o = bad_q ? CAUSE_RANGE : CAUSE_INJECT;
    end

    assign beat_ack_o = (state_q == SEQ_BEAT);
    assign busy_o     = (state_q != SEQ_IDLE);
    assign beat_idx_o = beat_q;
    assign line_o     = line_q;
    assign line_bad_o = bad_q;

endmodule

// File: rtl/isb_err_regs.sv
// Config registers: the fault control, the fault address and the fault
// syndrome. The first fault is held until software clears it. A fault
// that arrives together with a clear is captured.
// Assumes the clear strobe is decoded by the parent.
module isb_err_regs
    import isb_pkg::*;
#(
    parameter int AW = 16,
    parameter int BW = 3,
    localparam int CTL_W = BW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_addr_i,
    input  logic             cfg_we_i,
    input  logic [CTL_W-1:0] cfg_wdata_i,
    input  logic             clear_i,
    input  logic             beat_err_i,
    input  logic [1:0]       err_cause_i,
    input  logic [BW-1:0]    err_beat_i,
    input  logic [AW-1:0]    err_addr_i,
    output logic [AW-1:0]    cfg_rdata_o,
    output logic             ctrl_inj_en_o,
    output logic             ctrl_slow_o,
    output logic [BW-1:0]    ctrl_beat_o,
    output logic             syn_valid_o
);

    logic          inj_en_q;
    logic          slow_q;
    logic [BW-1:0] ibeat_q;
    logic          valid_q;
    logic [1:0]    cause_q;
    logic [BW-1:0] sbeat_q;
    logic [AW-1:0] eaddr_q;

    // Hold the fault control written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inj_en_q <= 1'b0;
            slow_q   <= 1'b0;
            ibeat_q  <= '0;
        end else if (cfg_we_i && (cfg_addr_i == CFG_CTRL)) begin
            inj_en_q <= cfg_wdata_i[0];
            slow_q   <= cfg_wdata_i[1];
            ibeat_q  <= cfg_wdata_i[2 +: BW];
        end
    end

    // Capture the first fault; a clear empties both registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            cause_q <= '0;
            sbeat_q <= '0;
            eaddr_q <= '0;
        end else if (beat_err_i && (!valid_q || clear_i)) begin
            valid_q <= 1'b1;
            cause_q <= err_cause_i;
            sbeat_q <= err_beat_i;
            eaddr_q <= err_addr_i;
        end else if (clear_i) begin
            valid_q <= 1'b0;
            cause_q <= '0;
            sbeat_q <= '0;
            eaddr_q <= '0;
        end
    end

    // Return the selected register.
    always_comb begin
        cfg_rdata_o = '0;
        case (cfg_addr_i)
            CFG_CTRL: begin
                cfg_rdata_o[0]       = inj_en_q;
                cfg_rdata_o[1]       = slow_q;
                cfg_rdata_o[2 +: BW] = ibeat_q;
            end
            CFG_EADDR: cfg_rdata_o = eaddr_q;
            CFG_SYND: begin
                cfg_rdata_o[0]       = valid_q;
                cfg_rdata_o[2:1]     = cause_q;
                cfg_rdata_o[3 +: BW] = sbeat_q;
            end
            default: cfg_rdata_o = '0;
        endcase
    end

    assign ctrl_inj_en_o = inj_en_q;
    assign ctrl_slow_o   = slow_q;
    assign ctrl_beat_o   = ibeat_q;
    assign syn_valid_o   = valid_q;

endmodule

// File: rtl/isb_slave.sv
// Instruction line fetch slave. It serves 8-word lines from an internal
// array, returning one word per cycle right after the grant. It injects
// faults on demand and latches the first fault for software.
// Assumes a single fetch master; the line index is the byte address
// above the line offset.
module isb_slave
    import isb_pkg::*;
#(
    parameter int AW    = 16,
    parameter int LINES = 16,
    parameter int BW    = 3,
    localparam int LAW   = AW - BW - 2,
    localparam int CTL_W = BW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [LAW-1:0]    req_line_i,
    output logic              req_ack_o,
    output logic              busy_o,
    output logic              rd_ack_o,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              rd_err_o,
    input  logic [1:0]        cfg_addr_i,
    input  logic              cfg_we_i,
    input  logic [CTL_W-1:0]  cfg_wdata_i,
    output logic [AW-1:0]     cfg_rdata_o
);

    localparam int LIW         = $clog2(LINES);
    localparam int DEPTH_WORDS = LINES << BW;

    logic              ctrl_inj_en;
    logic              ctrl_slow;
    logic [BW-1:0]     ctrl_beat;
    logic              syn_valid;
    logic              cfg_clear;
    logic [BW-1:0]     beat_idx;
    logic [LAW-1:0]    line_cur;
    logic              line_bad;
    logic [1:0]        err_cause;
    logic [WORD_W-1:0] rom_word;
    logic [AW-1:0]     err_addr;

    // Clear strobe: a 1 written to bit 0 of the syndrome register.
    assign cfg_clear = cfg_we_i && (cfg_addr_i == CFG_SYND) && cfg_wdata_i[0];

    isb_beat_seq #(.LAW(LAW), .BW(BW), .LINES(LINES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .req_line_i  (req_line_i),
        .slow_i      (ctrl_slow),
        .inj_en_i    (ctrl_inj_en),
        .inj_beat_i  (ctrl_beat),
        .req_ack_o   (req_ack_o),
        .busy_o      (busy_o),
        .beat_ack_o  (rd_ack_o),
        .beat_idx_o  (beat_idx),
        .line_o      (line_cur),
        .line_bad_o  (line_bad),
        .beat_err_o  (rd_err_o),
        .err_cause_o (err_cause)
    );

    isb_line_rom #(.DEPTH_WORDS(DEPTH_WORDS)) u_rom (
        .rd_idx_i  ({line_cur[LIW-1:0], beat_idx}),
        .rd_word_o (rom_word)
    );

    // Byte address of the word now on the bus.
    assign err_addr = {line_cur, beat_idx, 2'b00};

    // Drive data only on a valid, in-range word.
    assign rd_data_o = (rd_ack_o && !line_bad) ? rom_word : '0;

    isb_err_regs #(.AW(AW), .BW(BW)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_addr_i    (cfg_addr_i),
        .cfg_we_i      (cfg_we_i),
        .cfg_wdata_i   (cfg_wdata_i),
        .clear_i       (cfg_clear),
        .beat_err_i    (rd_err_o),
        .err_cause_i   (err_cause),
        .err_beat_i    (beat_idx),
        .err_addr_i    (err_addr),
        .cfg_rdata_o   (cfg_rdata_o),
        .ctrl_inj_en_o (ctrl_inj_en),
        .ctrl_slow_o   (ctrl_slow),
        .ctrl_beat_o   (ctrl_beat),
        .syn_valid_o   (syn_valid)
    );

endmodule

// File: rtl/isb_slave_chk.sv
// Protocol checker for the instruction line fetch slave, bound to the top.
// It counts the words of each line to check that the stream has no gaps.
module isb_slave_chk #(
    parameter int BW = 3
) (
    input logic clk,
    input logic rst_n,
    input logic req_ack,
    input logic rd_ack,
    input logic rd_err,
    input logic busy,
    input logic slow,
    input logic syn_valid,
    input logic clear
);

    localparam logic [BW-1:0] LAST_BEAT = '1;

    logic [BW-1:0] beats_seen;

    // Count the words delivered since the last grant.
    always_ff @(posedge clk) begin
        if (!rst_n)       beats_seen <= '0;
        else if (req_ack) beats_seen <= '0;
        else if (rd_ack)  beats_seen <= beats_seen + 1'b1;
    end

    p_busy_after_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> busy);
    p_no_grant_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ack);
    p_fast_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack && !slow |=> rd_ack);
    p_slow_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack && slow |=> !rd_ack);
    p_wait_then_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !rd_ack |=> rd_ack);
    p_no_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack && (beats_seen != LAST_BEAT) |=> rd_ack);
    p_line_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack && (beats_seen == LAST_BEAT) |=> !busy);
    p_err_with_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> rd_ack);
    p_err_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |=> !rd_err);
    p_hold_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        syn_valid && !clear |=> syn_valid);

endmodule

bind isb_slave isb_slave_chk #(.BW(BW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ack   (req_ack_o),
    .rd_ack    (rd_ack_o),
    .rd_err    (rd_err_o),
    .busy      (busy_o),
    .slow      (ctrl_slow),
    .syn_valid (syn_valid),
    .clear     (cfg_clear)
);

// File: tb/sim_isb_slave.sv
// Bench for the instruction line fetch slave. A behavioural model of
// queues and plain variables predicts every output on every cycle.
module sim_isb_slave;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        req_i;
    logic [10:0] req_line_i;
    logic        req_ack_o;
    logic        busy_o;
    logic        rd_ack_o;
    logic [31:0] rd_data_o;
    logic        rd_err_o;
    logic [1:0]  cfg_addr_i;
    logic        cfg_we_i;
    logic [4:0]  cfg_wdata_i;
    logic [15:0] cfg_rdata_o;

    int n_checks = 0;
    int n_fail   = 0;

    isb_slave u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .req_line_i  (req_line_i),
        .req_ack_o   (req_ack_o),
        .busy_o      (busy_o),
        .rd_ack_o    (rd_ack_o),
        .rd_data_o   (rd_data_o),
        .rd_err_o    (rd_err_o),
        .cfg_addr_i  (cfg_addr_i),
        .cfg_we_i    (cfg_we_i),
        .cfg_wdata_i (cfg_wdata_i),
        .cfg_rdata_o (cfg_rdata_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Model state: one queue entry per upcoming transfer cycle.
    bit          q_ack[$];
    logic [31:0] q_data[$];
    bit          q_err[$];
    logic [15:0] q_addr[$];
    logic [1:0]  q_cause[$];
    logic [2:0]  q_beat[$];

    bit          m_inj;
    bit          m_slow;
    logic [2:0]  m_ibeat;
    bit          m_valid;
    logic [1:0]  m_cause;
    logic [2:0]  m_sbeat;
    logic [15:0] m_eaddr;

    function automatic logic [31:0] exp_word(input int w);
        return {w[15:0] ^ 16'hC0DE, ~w[15:0]};
    endfunction

    function automatic logic [15:0] model_read(input logic [1:0] a);
        case (a)
            2'd0:    return {11'd0, m_ibeat, m_slow, m_inj};
            2'd1:    return m_eaddr;
            2'd2:    return {10'd0, m_sbeat, m_cause, m_valid};
            default: return 16'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare this cycle, advance the model over the edge, return at negedge.
    task automatic step();
        bit          e_busy, c_ack, c_err, accept, clr, o_slow, o_inj, bad;
        logic [31:0] c_data;
        logic [15:0] c_addr;
        logic [1:0]  c_cause;
        logic [2:0]  c_beat, o_ibeat;
        int          line;
        #(CLK_PERIOD/4);
        e_busy = (q_ack.size() != 0);
        if (e_busy) begin
            c_ack = q_ack[0]; c_data = q_data[0]; c_err = q_err[0];
            c_addr = q_addr[0]; c_cause = q_cause[0]; c_beat = q_beat[0];
        end else begin
            c_ack = 0; c_data = '0; c_err = 0; c_addr = '0; c_cause = '0; c_beat = '0;
        end
        accept = req_i && !e_busy;
        check("R1 req_ack", {31'd0, req_ack_o}, {31'd0, accept});
        check("R1 busy", {31'd0, busy_o}, {31'd0, e_busy});
        check("R2/R3 rd_ack", {31'd0, rd_ack_o}, {31'd0, c_ack});
        check("R4 rd_data", rd_data_o, c_data);
        check("R5/R6 rd_err", {31'd0, rd_err_o}, {31'd0, c_err});
        check("R7/R10 cfg_rdata", {16'd0, cfg_rdata_o}, {16'd0, model_read(cfg_addr_i)});
        // R9: the clear strobe, with a same-cycle fault taking precedence
        clr = cfg_we_i && (cfg_addr_i == 2'd2) && cfg_wdata_i[0];
        if (c_err && (!m_valid || clr)) begin
            m_valid = 1; m_cause = c_cause; m_sbeat = c_beat; m_eaddr = c_addr;
        end else if (clr) begin
            m_valid = 0; m_cause = '0; m_sbeat = '0; m_eaddr = '0;
        end
        o_slow = m_slow; o_inj = m_inj; o_ibeat = m_ibeat;
        if (cfg_we_i && cfg_addr_i == 2'd0) begin
            m_inj = cfg_wdata_i[0]; m_slow = cfg_wdata_i[1]; m_ibeat = cfg_wdata_i[4:2];
        end
        if (e_busy) begin
            void'(q_ack.pop_front()); void'(q_data.pop_front()); void'(q_err.pop_front());
            void'(q_addr.pop_front()); void'(q_cause.pop_front()); void'(q_beat.pop_front());
        end
        if (accept) begin
            line = int'(req_line_i);
            bad  = (line >= 16);
            if (o_slow) begin
                q_ack.push_back(0); q_data.push_back('0); q_err.push_back(0);
                q_addr.push_back('0); q_cause.push_back('0); q_beat.push_back('0);
            end
            for (int b = 0; b < 8; b++) begin
                q_ack.push_back(1);
                q_data.push_back(bad ? 32'd0 : exp_word(line * 8 + b));
                q_err.push_back(bad ? (b == 0) : (o_inj && (b == int'(o_ibeat))));
                q_addr.push_back(16'(line * 32 + b * 4));
                q_cause.push_back(bad ? 2'b11 : 2'b01);
                q_beat.push_back(3'(b));
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        req_i = 0; req_line_i = '0; cfg_we_i = 0; cfg_addr_i = 2'd0; cfg_wdata_i = '0;
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [4:0] d);
        idle_inputs();
        cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
        step();
        idle_inputs();
    endtask

    task automatic cfg_read(input logic [1:0] a);
        idle_inputs();
        cfg_addr_i = a;
        step();
        idle_inputs();
    endtask

    // One request, then n cycles total; optional config write at cycle wr_at.
    task automatic read_line(input int line, input int n, input int wr_at,
                             input logic [1:0] wa, input logic [4:0] wd);
        for (int c = 0; c < n; c++) begin
            idle_inputs();
            if (c == 0) begin req_i = 1; req_line_i = 11'(line); end
            if (c == wr_at) begin cfg_we_i = 1; cfg_addr_i = wa; cfg_wdata_i = wd; end
            step();
        end
        idle_inputs();
    endtask

    task automatic read_fault_regs();
        cfg_read(2'd1);
        cfg_read(2'd2);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        m_inj = 0; m_slow = 0; m_ibeat = '0;
        m_valid = 0; m_cause = '0; m_sbeat = '0; m_eaddr = '0;
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R10: reset state of all registers and outputs
        for (int a = 0; a < 4; a++) cfg_read(2'(a));

        // R1 R2 R3 R4: plain fast line read
        read_line(3, 10, -1, 2'd0, 5'd0);

        // R1: request held high while busy; regranted only when idle
        for (int c = 0; c < 20; c++) begin
            idle_inputs(); req_i = 1; req_line_i = 11'd5; step();
        end
        idle_inputs();
        repeat (9) step();

        // R5 R7: inject on word 5
        cfg_write(2'd0, 5'h15);
        cfg_read(2'd0);
        read_line(7, 10, -1, 2'd0, 5'd0);
        read_fault_regs();

        // R8: second fault while valid does not overwrite
        cfg_write(2'd0, 5'h09);
        read_line(9, 10, -1, 2'd0, 5'd0);
        read_fault_regs();

        // R9: writes that must not clear
        cfg_write(2'd1, 5'h1F);
        cfg_write(2'd2, 5'h1E);
        read_fault_regs();

        // R9: clear
        cfg_write(2'd2, 5'h01);
        read_fault_regs();

        // R6: out-of-range line, injection still enabled on word 2
        read_line(20, 10, -1, 2'd0, 5'd0);
        read_fault_regs();
        cfg_write(2'd2, 5'h01);

        // R5: last word, control changed mid-line has no effect on it
        cfg_write(2'd0, 5'h1D);
        read_line(2, 10, 3, 2'd0, 5'h00);
        read_fault_regs();
        cfg_write(2'd2, 5'h01);

        // R9: fault captured in the same cycle as a clear
        cfg_write(2'd0, 5'h01);
        read_line(4, 10, -1, 2'd0, 5'd0);
        read_line(6, 10, 1, 2'd2, 5'h01);
        read_fault_regs();
        cfg_write(2'd2, 5'h01);

        // R2: slow mode, then slow mode with a fault on word 0 of the last line
        cfg_write(2'd0, 5'h02);
        read_line(1, 11, -1, 2'd0, 5'd0);
        cfg_write(2'd0, 5'h03);
        read_line(15, 11, -1, 2'd0, 5'd0);
        read_fault_regs();
        cfg_read(2'd3);

        summary();
        $finish;
    end

endmodule